// File: doc/BRIEF.md
# Multi-Lag Complex Code Correlator

This block searches a received stream of complex samples for a known spreading pattern. A block of samples is written into one half of a two-half sample store. A complex code with one bit per chip is loaded beside it. Once a block is complete and a code is present, the engine correlates the block against the code at every lag of the search window. It produces an in-phase and a quadrature sum for each lag. The code steps once per chip, and every chip covers `OSR` consecutive sample phases. Lag k therefore sums sample `i*OSR + k` against chip i over all chips.

A bank of `PAR` lanes does the work, one lag per lane. In each cycle every lane adds one chip's complex product, which takes four signed add/subtract operations because each code value is ±1. A run therefore takes `(NLAGS/PAR)*NCHIPS` cycles. The finished sums go into one bank of a two-bank result store. When the last lag group is written, the banks swap and a one-cycle ready pulse appears. A registered read port returns several lags per word, spaced `OSR` apart, so that lags of the same sampling phase come out together. The next sample block can be written while the current one is processed. `NLAGS` must be even and a multiple of `PAR`.

Top module: `corr_engine`

## Requirements
- R1: The I and Q results for lag k are the sums over chips i = 0..NCHIPS−1 of the complex product of sample `i*OSR + k` of the block and chip i of the code. A code bit of 0 stands for +1 and a bit of 1 stands for −1. The I part is `sI*cI − sQ*cQ` and the Q part is `sI*cQ + sQ*cI`. Chip i is bit i of `code_i_bits` and `code_q_bits`.
- R2: Each write on `smp_valid` stores one sample: I is the two's-complement value in `smp_word[NBITS-1:0]` and Q is the value in `smp_word[2*NBITS-1:NBITS]`. A block is `(NCHIPS−1)*OSR + NLAGS` consecutive accepted samples, sample 0 first.
- R3: Each result is `NBITS+2+log2(NCHIPS)` bits in two's complement, and holds the exact sum even when every term has the largest possible magnitude.
- R4: The read word for address a holds `2*NPAIRS` slots. Slot j carries lag `a + j*OSR`, with I in its low RW bits and Q in its high RW bits, and slot 0 sits at the least significant end. A slot whose lag is NLAGS or more reads as zero.
- R5: With the engine idle and a code loaded, `res_ready` is high for exactly one cycle, `(NLAGS/PAR)*NCHIPS + 1` clock edges after the edge that captures the last sample of a block.
- R6: While one block is processed, the next block is accepted into the other half. It starts on the edge after the current run ends, so ready pulses are `(NLAGS/PAR)*NCHIPS + 1` cycles apart, and each block's results are unaffected by writes made during its run.
- R7: A sample written while both halves hold unprocessed or in-progress blocks is discarded, and the block being filled next starts from the following accepted sample.
- R8: A pulse on `code_load` replaces the code only while the engine is idle, and is ignored during a run. No run starts until a code has been loaded since reset.
- R9: `res_word` shows the word at `res_addr` one clock edge after the address is presented, taken from the results of the most recently completed block until the next ready pulse.
- R10: After reset `res_ready` is low and every result address reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Write one sample this cycle |
| smp_word | input | 2*NBITS | Packed sample, I low half, Q high half |
| code_load | input | 1 | Load the code vectors |
| code_i_bits | input | NCHIPS | In-phase code, bit i is chip i, 1 means −1 |
| code_q_bits | input | NCHIPS | Quadrature code, bit i is chip i, 1 means −1 |
| res_addr | input | log2(NLAGS) | Result read address |
| res_word | output | 2*NPAIRS*2*RW | Registered result word |
| res_ready | output | 1 | One-cycle pulse when a block's results are complete |

## Verification
The hardest state to reach is both sample halves occupied at the same moment: one block mid-run and the next fully written. Only then are further writes discarded, and only then does a run start immediately after the previous one ends. The stimulus reaches it with a long unbroken burst of writes, shorter per block than one run, so that the second block completes well before the first run ends. The bench's model decides which words were accepted, and the reader confirms that each block's sums contain exactly those words and that the ready pulses come back to back.

// File: rtl/corr_pkg.sv
`timescale 1ns/1ps
package corr_pkg;
    typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;

    function automatic int safe_clog2(input int v);
        return (v <= 1) ? 1 : $clog2(v);
    endfunction
endpackage

// File: rtl/corr_sample_buf.sv
`timescale 1ns/1ps
module corr_sample_buf #(
    parameter int SW    = 8,
    parameter int NSAMP = 22,
    parameter int PAR   = 2,
    parameter int IW    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_word,
    input  logic [IW-1:0]     rd_base,
    input  logic              release_half,
    output logic [PAR*SW-1:0] rd_samples,
    output logic              half_ready,
    output logic [1:0]        full_flags,
    output logic [IW-1:0]     fill_ptr
);
    typedef struct packed {
        logic          wsel;
        logic          rsel;
        logic [1:0]    full;
        logic [IW-1:0] wptr;
    } ctl_t;

    ctl_t        ctl_d, ctl_q;
    logic        take;
    logic [SW-1:0] mem_q [2][NSAMP];

    always_comb begin
        ctl_d = ctl_q;
        take  = wr_en && !ctl_q.full[ctl_q.wsel];
        if (release_half) begin
            ctl_d.full[ctl_q.rsel] = 1'b0;
            ctl_d.rsel             = ~ctl_q.rsel;
        end
        if (take) begin
            if (ctl_q.wptr == IW'(NSAMP - 1)) begin
                ctl_d.wptr             = '0;
                ctl_d.full[ctl_q.wsel] = 1'b1;
                ctl_d.wsel             = ~ctl_q.wsel;
            end else begin
                ctl_d.wptr = ctl_q.wptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_ff @(posedge clk) begin
        if (take) mem_q[ctl_q.wsel][ctl_q.wptr] <= wr_word;
    end

    for (genvar l = 0; l < PAR; l++) begin : g_rd
        always_comb begin
            int idx;
            idx = int'(rd_base) + l;
            if (idx < NSAMP) rd_samples[l*SW +: SW] = mem_q[ctl_q.rsel][IW'(idx)];
            else             rd_samples[l*SW +: SW] = '0;
        end
    end

    assign half_ready = ctl_q.full[ctl_q.rsel];
    assign full_flags = ctl_q.full;
    assign fill_ptr   = ctl_q.wptr;
endmodule

// File: rtl/corr_mac_lane.sv
`timescale 1ns/1ps
module corr_mac_lane #(
    parameter int NBITS = 4,
    parameter int RW    = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic               last,
    input  logic [2*NBITS-1:0] samp,
    input  logic               cneg_i,
    input  logic               cneg_q,
    output logic [RW-1:0]      sum_i,
    output logic [RW-1:0]      sum_q
);
    typedef struct packed {
        logic signed [RW-1:0] acc_i;
        logic signed [RW-1:0] acc_q;
    } acc_t;

    acc_t acc_d, acc_q;
    logic signed [RW-1:0] s_i, s_q, t_i, t_q, tot_i, tot_q;

    always_comb begin
        s_i   = {{(RW-NBITS){samp[NBITS-1]}},   samp[NBITS-1:0]};
        s_q   = {{(RW-NBITS){samp[2*NBITS-1]}}, samp[2*NBITS-1:NBITS]};
        // (sI + j sQ)(cI + j cQ) with each code value equal to +1 or -1
        t_i   = (cneg_i ? -s_i : s_i) - (cneg_q ? -s_q : s_q);
        t_q   = (cneg_q ? -s_i : s_i) + (cneg_i ? -s_q : s_q);
        tot_i = acc_q.acc_i + t_i;
        tot_q = acc_q.acc_q + t_q;
        acc_d = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (step) begin
            acc_d.acc_i = last ? '0 : tot_i;
            acc_d.acc_q = last ? '0 : tot_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign sum_i = tot_i;
    assign sum_q = tot_q;
endmodule

// File: rtl/corr_result_mem.sv
`timescale 1ns/1ps
module corr_result_mem #(
    parameter int NLAGS = 8,
    parameter int PAR   = 2,
    parameter int RW    = 9,
    parameter int OSR   = 2,
    parameter int SLOTS = 2,
    parameter int AW    = 3,
    parameter int GW    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [GW-1:0]         wr_grp,
    input  logic [PAR*RW-1:0]     wr_i,
    input  logic [PAR*RW-1:0]     wr_q,
    input  logic                  swap,
    input  logic [AW-1:0]         rd_addr,
    output logic [SLOTS*2*RW-1:0] rd_word
);
    typedef struct packed {
        logic                  rbank;
        logic [SLOTS*2*RW-1:0] word;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [2*RW-1:0] bank_q [2][NLAGS];

    always_comb begin
        rd_d       = rd_q;
        rd_d.rbank = swap ? ~rd_q.rbank : rd_q.rbank;
        for (int j = 0; j < SLOTS; j++) begin
            int lag;
            lag = int'(rd_addr) + j * OSR;
            if (lag < NLAGS) rd_d.word[j*2*RW +: 2*RW] = bank_q[rd_q.rbank][AW'(lag)];
            else             rd_d.word[j*2*RW +: 2*RW] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int k = 0; k < NLAGS; k++)
                    bank_q[b][k] <= '0;
        end else if (wr_en) begin
            for (int l = 0; l < PAR; l++)
                bank_q[~rd_q.rbank][AW'(int'(wr_grp) * PAR + l)] <= {wr_q[l*RW +: RW], wr_i[l*RW +: RW]};
        end
    end

    assign rd_word = rd_q.word;
endmodule

// File: rtl/corr_engine.sv
`timescale 1ns/1ps
module corr_engine
    import corr_pkg::*;
#(
    parameter int NBITS  = 4,
    parameter int NCHIPS = 8,
    parameter int OSR    = 2,
    parameter int NLAGS  = 8,
    parameter int PAR    = 2,
    parameter int NPAIRS = 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  smp_valid,
    input  logic [2*NBITS-1:0]                    smp_word,
    input  logic                                  code_load,
    input  logic [NCHIPS-1:0]                     code_i_bits,
    input  logic [NCHIPS-1:0]                     code_q_bits,
    input  logic [$clog2(NLAGS)-1:0]              res_addr,
    output logic [2*NPAIRS*2*(NBITS+2+$clog2(NCHIPS))-1:0] res_word,
    output logic                                  res_ready
);
    localparam int SW      = 2 * NBITS;
    localparam int RW      = NBITS + 2 + $clog2(NCHIPS);
    localparam int NSAMP   = (NCHIPS - 1) * OSR + NLAGS;
    localparam int NGROUPS = NLAGS / PAR;
    localparam int SLOTS   = 2 * NPAIRS;
    localparam int AW      = $clog2(NLAGS);
    localparam int CW      = safe_clog2(NCHIPS);
    localparam int GW      = safe_clog2(NGROUPS);
    localparam int IW      = $clog2(NSAMP + 1);

    typedef struct packed {
        eng_state_e        st;
        logic [CW-1:0]     chip;
        logic [GW-1:0]     grp;
        logic [NCHIPS-1:0] code_i;
        logic [NCHIPS-1:0] code_q;
        logic              code_vld;
        logic              ready;
    } eng_t;

    eng_t eng_d, eng_q;
    logic acc_clear, acc_step, acc_last, res_wr, run_done;
    logic [IW-1:0]     rd_base;
    logic [PAR*SW-1:0] lane_samp;
    logic [PAR*RW-1:0] lane_i, lane_q;
    logic              buf_avail;
    logic [1:0]        buf_full;
    logic [IW-1:0]     buf_wptr;
    logic              busy_w, code_vld_q;
    logic [NCHIPS-1:0] code_i_q, code_q_q;

    always_comb begin
        eng_d     = eng_q;
        eng_d.ready = 1'b0;
        acc_clear = 1'b0;
        acc_step  = 1'b0;
        acc_last  = 1'b0;
        res_wr    = 1'b0;
        run_done  = 1'b0;
        if (code_load && eng_q.st == ENG_IDLE) begin
            eng_d.code_i   = code_i_bits;
            eng_d.code_q   = code_q_bits;
            eng_d.code_vld = 1'b1;
        end
        unique case (eng_q.st)
            ENG_IDLE: begin
                if (buf_avail && eng_q.code_vld) begin
                    eng_d.st   = ENG_RUN;
                    eng_d.chip = '0;
                    eng_d.grp  = '0;
                    acc_clear  = 1'b1;
                end
            end
            ENG_RUN: begin
                acc_step = 1'b1;
                acc_last = (eng_q.chip == CW'(NCHIPS - 1));
                if (acc_last) begin
                    res_wr     = 1'b1;
                    eng_d.chip = '0;
                    if (eng_q.grp == GW'(NGROUPS - 1)) begin
                        eng_d.st    = ENG_IDLE;
                        eng_d.ready = 1'b1;
                        run_done    = 1'b1;
                    end else begin
                        eng_d.grp = eng_q.grp + 1'b1;
                    end
                end else begin
                    eng_d.chip = eng_q.chip + 1'b1;
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
        rd_base = IW'(int'(eng_q.chip) * OSR + int'(eng_q.grp) * PAR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{st: ENG_IDLE, default: '0};
        else        eng_q <= eng_d;
    end

    corr_sample_buf #(.SW(SW), .NSAMP(NSAMP), .PAR(PAR), .IW(IW)) u_sbuf (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (smp_valid),
        .wr_word      (smp_word),
        .rd_base      (rd_base),
        .release_half (run_done),
        .rd_samples   (lane_samp),
        .half_ready   (buf_avail),
        .full_flags   (buf_full),
        .fill_ptr     (buf_wptr)
    );

    for (genvar l = 0; l < PAR; l++) begin : g_lane
        corr_mac_lane #(.NBITS(NBITS), .RW(RW)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (acc_clear),
            .step   (acc_step),
            .last   (acc_last),
            .samp   (lane_samp[l*SW +: SW]),
            .cneg_i (eng_q.code_i[eng_q.chip]),
            .cneg_q (eng_q.code_q[eng_q.chip]),
            .sum_i  (lane_i[l*RW +: RW]),
            .sum_q  (lane_q[l*RW +: RW])
        );
    end

    corr_result_mem #(
        .NLAGS(NLAGS), .PAR(PAR), .RW(RW), .OSR(OSR),
        .SLOTS(SLOTS), .AW(AW), .GW(GW)
    ) u_rmem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res_wr),
        .wr_grp  (eng_q.grp),
        .wr_i    (lane_i),
        .wr_q    (lane_q),
        .swap    (run_done),
        .rd_addr (res_addr),
        .rd_word (res_word)
    );

    assign busy_w     = (eng_q.st == ENG_RUN);
    assign code_vld_q = eng_q.code_vld;
    assign code_i_q   = eng_q.code_i;
    assign code_q_q   = eng_q.code_q;
    assign res_ready  = eng_q.ready;
endmodule

// File: rtl/corr_checker.sv
`timescale 1ns/1ps
module corr_checker #(
    parameter int NCHIPS = 8,
    parameter int NSAMP  = 22,
    parameter int IW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              ready,
    input logic              code_load,
    input logic              code_vld,
    input logic [NCHIPS-1:0] code_i_q,
    input logic [NCHIPS-1:0] code_q_q,
    input logic [1:0]        full,
    input logic [IW-1:0]     wptr,
    input logic              avail
);
    assert_ready_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    assert_ready_ends_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(busy));

    assert_code_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && code_load) |=> ($stable(code_i_q) && $stable(code_q_q)));

    assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (&full) |=> $stable(wptr));

    assert_start_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(avail && code_vld));

    assert_fill_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wptr) < NSAMP);
endmodule

bind corr_engine corr_checker #(.NCHIPS(NCHIPS), .NSAMP(NSAMP), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_w),
    .ready     (res_ready),
    .code_load (code_load),
    .code_vld  (code_vld_q),
    .code_i_q  (code_i_q),
    .code_q_q  (code_q_q),
    .full      (buf_full),
    .wptr      (buf_wptr),
    .avail     (buf_avail)
);

// File: tb/tb_corr_engine.sv
`timescale 1ns/1ps
module tb_corr_engine;
    localparam int NB    = 4;
    localparam int NCH   = 8;
    localparam int OSR   = 2;
    localparam int NLAG  = 8;
    localparam int PAR   = 2;
    localparam int NPAIR = 1;
    localparam int NSAMP = (NCH - 1) * OSR + NLAG;
    localparam int RW    = NB + 2 + $clog2(NCH);
    localparam int SLOTS = 2 * NPAIR;
    localparam int AW    = $clog2(NLAG);
    localparam int T     = (NLAG / PAR) * NCH;

    logic                   clk, rst_n, smp_valid, code_load;
    logic [2*NB-1:0]        smp_word;
    logic [NCH-1:0]         code_i_bits, code_q_bits;
    logic [AW-1:0]          res_addr;
    logic [SLOTS*2*RW-1:0]  res_word;
    logic                   res_ready;

    corr_engine #(.NBITS(NB), .NCHIPS(NCH), .OSR(OSR), .NLAGS(NLAG), .PAR(PAR), .NPAIRS(NPAIR)) dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_word(smp_word),
        .code_load(code_load), .code_i_bits(code_i_bits), .code_q_bits(code_q_bits),
        .res_addr(res_addr), .res_word(res_word), .res_ready(res_ready)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference: block slots, pending queue, run countdown
    int             m_si [8][NSAMP];
    int             m_sq [8][NSAMP];
    logic [NCH-1:0] m_ci [8];
    logic [NCH-1:0] m_cq [8];
    int             pend_q[$];
    int             done_q[$];
    int             fill_cnt, fill_slot, busy_cnt, run_slot;
    logic [NCH-1:0] cur_ci, cur_cq;
    bit             cur_vld, exp_ready;

    always @(posedge clk) begin : model
        int             occ;
        bit             acc;
        logic [NCH-1:0] nci, ncq;
        bit             nvld;
        if (!rst_n) begin
            pend_q.delete(); done_q.delete();
            fill_cnt = 0; fill_slot = 0; busy_cnt = 0; run_slot = 0;
            cur_ci = '0; cur_cq = '0; cur_vld = 0; exp_ready = 0;
        end else begin
            occ  = pend_q.size() + ((busy_cnt > 0) ? 1 : 0);
            acc  = smp_valid && (occ < 2);
            nci  = cur_ci; ncq = cur_cq; nvld = cur_vld;
            if (code_load && busy_cnt == 0) begin
                nci = code_i_bits; ncq = code_q_bits; nvld = 1;
            end
            exp_ready = 0;
            if (busy_cnt > 0) begin
                busy_cnt--;
                if (busy_cnt == 0) begin
                    exp_ready = 1;
                    done_q.push_back(run_slot);
                end
            end else if (pend_q.size() > 0 && cur_vld) begin
                run_slot = pend_q.pop_front();
                busy_cnt = T;
                m_ci[run_slot] = nci;
                m_cq[run_slot] = ncq;
            end
            cur_ci = nci; cur_cq = ncq; cur_vld = nvld;
            if (acc) begin
                m_si[fill_slot % 8][fill_cnt] = int'($signed(smp_word[NB-1:0]));
                m_sq[fill_slot % 8][fill_cnt] = int'($signed(smp_word[2*NB-1:NB]));
                fill_cnt++;
                if (fill_cnt == NSAMP) begin
                    pend_q.push_back(fill_slot % 8);
                    fill_slot++;
                    fill_cnt = 0;
                end
            end
        end
    end

    // R5 / R6: ready pulse compared on every clock
    always @(negedge clk) begin
        if (rst_n) check(res_ready === exp_ready, "R5 R6 ready pulse timing", res_ready, exp_ready);
    end

    function automatic void lag_ref(input int slot, input int lag, output int ri, output int rq);
        int ci, cq, si, sq;
        ri = 0; rq = 0;
        for (int i = 0; i < NCH; i++) begin
            ci = m_ci[slot][i] ? -1 : 1;
            cq = m_cq[slot][i] ? -1 : 1;
            si = m_si[slot][i*OSR + lag];
            sq = m_sq[slot][i*OSR + lag];
            ri += si * ci - sq * cq;
            rq += si * cq + sq * ci;
        end
    endfunction

    task automatic read_block(input int slot);
        int ri, rq, lag, act_i, act_q;
        for (int a = 0; a < NLAG; a++) begin
            res_addr = AW'(a);
            @(negedge clk);
            for (int j = 0; j < SLOTS; j++) begin
                lag = a + j * OSR;
                if (lag < NLAG) lag_ref(slot, lag, ri, rq);
                else begin ri = 0; rq = 0; end
                act_i = int'($signed(res_word[(2*j)*RW +: RW]));
                act_q = int'($signed(res_word[(2*j+1)*RW +: RW]));
                check(act_i == ri, "R1/R2/R3/R4/R7/R9 lag I", act_i, ri);
                check(act_q == rq, "R1/R2/R3/R4/R7/R9 lag Q", act_q, rq);
            end
        end
    endtask

    initial begin : reader
        int slot;
        res_addr = '0;
        wait (rst_n === 1'b1);
        repeat (2) @(negedge clk);
        for (int a = 0; a < NLAG; a++) begin
            res_addr = AW'(a);
            @(negedge clk);
            check(res_word == '0, "R10 reset contents", longint'(res_word), 0);
        end
        forever begin
            @(negedge clk);
            if (res_ready) begin
                if (done_q.size() == 0) check(1'b0, "R5 unexpected ready", 1, 0);
                else begin
                    slot = done_q.pop_front();
                    read_block(slot);
                end
            end
        end
    end

    task automatic push_samples(input int n, input int mode);
        for (int k = 0; k < n; k++) begin
            smp_valid = 1'b1;
            case (mode)
                1:       smp_word = {4'h8, 4'h8};
                2:       smp_word = (k % 2 == 0) ? {4'h8, 4'h7} : {4'h7, 4'h8};
                default: smp_word = 8'($urandom_range(0, 255));
            endcase
            @(negedge clk);
        end
        smp_valid = 1'b0;
    endtask

    task automatic load_code(input logic [NCH-1:0] ci, input logic [NCH-1:0] cq);
        code_load = 1'b1; code_i_bits = ci; code_q_bits = cq;
        @(negedge clk);
        code_load = 1'b0;
    endtask

    initial begin : main
        smp_valid = 0; smp_word = '0; code_load = 0; code_i_bits = '0; code_q_bits = '0;
        rst_n = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        check(res_ready == 1'b0, "R10 ready low after reset", res_ready, 0);
        repeat (12) @(negedge clk);
        // R8: full block but no code yet, so nothing may start
        push_samples(NSAMP, 0);
        repeat (40) @(negedge clk);
        load_code(NCH'($urandom), NCH'($urandom));
        repeat (T + 20) @(negedge clk);
        // R3: largest magnitude terms
        load_code('1, '0);
        push_samples(NSAMP, 1);
        repeat (8) @(negedge clk);
        load_code(NCH'($urandom), NCH'($urandom)); // R8: ignored during run
        repeat (T + 20) @(negedge clk);
        load_code(NCH'($urandom), NCH'($urandom));
        push_samples(NSAMP, 2);
        repeat (T + 20) @(negedge clk);
        // R6 / R7: continuous burst fills both halves and overruns them
        push_samples(4 * NSAMP, 0);
        repeat (3 * T + 60) @(negedge clk);
        check(done_q.size() == 0 && pend_q.size() == 0 && busy_cnt == 0,
              "R6 all complete blocks processed", done_q.size() + pend_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule